// File: doc/BRIEF.md
# Dual-Link Pixel Stream Merger

This block rebuilds a single video line from two pixel links that each carry a share of it. Every link starts a line with a one-cycle line-start pulse and then delivers its pixels under a valid strobe. Gaps between strobes are allowed, so a line may arrive as several packets. The pixels of each link go into their own buffer. A sequencer then takes them out in display order and sends them on one output stream, marking the first and the last pixel of every line. All ports share one clock.

The line can be split in two ways. In halves mode, link A carries the first `cfg_left_len` pixels of the line and link B carries the rest. In group mode, the line is cut into groups that alternate, starting with link A. Each link has its own group length, which can be set from 1 to 64 pixels. When the programmed line length has been emitted, the line ends, even if that is part way through a group. If the link whose turn it is has no pixel buffered, the output waits for it, so a fixed offset between the two links does not change the result. A small monitor compares the line starts of the two links. It raises a sticky error when one link falls more than one line behind the other.

Top module: `dual_link_merger`

## Requirements
- R1: After reset, `out_valid`, `out_sol`, `out_eol` and `skew_err` are 0.
- R2: When `cfg_mode`=0 (halves), output positions 0 to `cfg_left_len`-1 come, in arrival order, from link A. The remaining positions up to `cfg_line_len`-1 come from link B.
- R3: When `cfg_mode`=1 (groups), a group-length code v selects v+1 pixels. The line starts with a group from link A, whose code is `cfg_grp_a`. After that, groups alternate with link B, whose code is `cfg_grp_b`.
- R4: Gaps in either input strobe, and any offset between the two links' line starts, change only when pixels come out, never their order. The output idles while the link whose turn it is has nothing buffered.
- R5: Each line produces exactly `cfg_line_len` output beats. `out_sol` is set on the first beat and `out_eol` on the last.
- R6: A line that ends part way through a group is closed at once. The next line starts on link A with a full link-A group.
- R7: `skew_err` becomes 1 and stays 1 until reset in two cases. The first is a line start on link A alone while link A already leads by one or more lines. The second is a line start on link B alone while link B already leads. Line starts on both links in the same cycle leave the lead unchanged.
- R8: Each link buffer holds `FIFO_DEPTH` pixels without loss. One link can therefore hold a whole 64-pixel group while the other link's group is being emitted.
- R9: A buffered pixel whose turn has come appears on the output in the next cycle. A pixel strobed in while its link is awaited appears two cycles after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both links and the output |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | 0 = halves split, 1 = group split |
| cfg_line_len | input | LW | Output line length in pixels |
| cfg_left_len | input | LW | Pixels taken from link A in halves mode |
| cfg_grp_a | input | 6 | Link A group length minus one |
| cfg_grp_b | input | 6 | Link B group length minus one |
| a_hss | input | 1 | Link A line-start pulse |
| a_valid | input | 1 | Link A pixel strobe |
| a_pixel | input | PIX_W | Link A pixel |
| b_hss | input | 1 | Link B line-start pulse |
| b_valid | input | 1 | Link B pixel strobe |
| b_pixel | input | PIX_W | Link B pixel |
| out_valid | output | 1 | Output pixel strobe |
| out_pixel | output | PIX_W | Output pixel |
| out_sol | output | 1 | First pixel of a line |
| out_eol | output | 1 | Last pixel of a line |
| skew_err | output | 1 | Sticky line-start skew error |

## Verification
The bench builds the block with PIX_W=16, FIFO_DEPTH=64 and LINE_MAX=255. Sixteen-bit pixels let every pixel carry its line number and its position, so any reordering shows up directly on the output. A 64-entry buffer matches the largest group length. A 128-pixel line split into two 64-pixel groups therefore fills link B's buffer to its last entry, which tests the full-depth case. Short lines keep every case, including group lengths of 1 and 64, lines ending part way through a group, an early link B and the skew error, within a few thousand cycles.

// File: rtl/dlm_pkg.sv
package dlm_pkg;

    typedef enum logic {
        SPLIT_HALVES = 1'b0,
        SPLIT_GROUPS = 1'b1
    } split_e;

    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } src_e;

    localparam int GRP_CODE_W = 6;
    localparam int GRP_LEN_W  = GRP_CODE_W + 1;

    function automatic logic [GRP_LEN_W-1:0] grp_len(input logic [GRP_CODE_W-1:0] code);
        return {1'b0, code} + GRP_LEN_W'(1);
    endfunction

    function automatic src_e other_src(input src_e s);
        return (s == SRC_A) ? SRC_B : SRC_A;
    endfunction

endpackage

// File: rtl/pix_fifo.sv
module pix_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 2048
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty
);
    // DEPTH must be a power of two so the pointers wrap on their own.
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW:0]   fill;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + AW'(1);
            if (pop)  rd_ptr <= rd_ptr + AW'(1);
            case ({push, pop})
                2'b10:   fill <= fill + (AW+1)'(1);
                2'b01:   fill <= fill - (AW+1)'(1);
                default: fill <= fill;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (fill == '0);

endmodule

// File: rtl/skew_monitor.sv
module skew_monitor (
    input  logic clk,
    input  logic rst,
    input  logic hss_a,
    input  logic hss_b,
    output logic err
);
    // lead = line starts seen on A minus those seen on B, clamped to +/-2
    logic signed [2:0] lead;

    always_ff @(posedge clk) begin
        if (rst) begin
            lead <= '0;
            err  <= 1'b0;
        end else if (hss_a && !hss_b) begin
            if (lead >= 3'sd1) err <= 1'b1;
            if (lead <  3'sd2) lead <= lead + 3'sd1;
        end else if (hss_b && !hss_a) begin
            if (lead <= -3'sd1) err <= 1'b1;
            if (lead >  -3'sd2) lead <= lead - 3'sd1;
        end
    end

endmodule

// File: rtl/merge_sequencer.sv
module merge_sequencer
    import dlm_pkg::*;
#(
    parameter int W  = 24,
    parameter int LW = 13
) (
    input  logic                  clk,
    input  logic                  rst,
    input  split_e                mode,
    input  logic [LW-1:0]         line_len,
    input  logic [LW-1:0]         left_len,
    input  logic [GRP_CODE_W-1:0] grp_a,
    input  logic [GRP_CODE_W-1:0] grp_b,
    input  logic                  empty_a,
    input  logic                  empty_b,
    input  logic [W-1:0]          head_a,
    input  logic [W-1:0]          head_b,
    output logic                  pop_a,
    output logic                  pop_b,
    output logic                  out_valid,
    output logic [W-1:0]          out_data,
    output logic                  out_sol,
    output logic                  out_eol
);
    logic [LW-1:0]        pos;
    src_e                 grp_src;
    logic [GRP_LEN_W-1:0] grp_left;

    src_e                 cur_src;
    src_e                 next_src;
    logic [GRP_LEN_W-1:0] grp_now;
    logic                 take;
    logic                 last;

    always_comb begin
        if (mode == SPLIT_HALVES) begin
            cur_src = (pos >= left_len) ? SRC_B : SRC_A;
        end else begin
            cur_src = (pos == '0) ? SRC_A : grp_src;
        end
        grp_now  = (pos == '0) ? grp_len(grp_a) : grp_left;
        next_src = other_src(cur_src);
        take     = (line_len != '0) &&
                   ((cur_src == SRC_A) ? !empty_a : !empty_b);
        last     = (pos == line_len - LW'(1));
        pop_a    = take && (cur_src == SRC_A);
        pop_b    = take && (cur_src == SRC_B);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos       <= '0;
            grp_src   <= SRC_A;
            grp_left  <= '0;
            out_valid <= 1'b0;
            out_sol   <= 1'b0;
            out_eol   <= 1'b0;
        end else begin
            out_valid <= take;
            out_sol   <= take && (pos == '0);
            out_eol   <= take && last;
            if (take) begin
                pos <= last ? '0 : pos + LW'(1);
                if (grp_now == GRP_LEN_W'(1)) begin
                    grp_src  <= next_src;
                    grp_left <= (next_src == SRC_A) ? grp_len(grp_a) : grp_len(grp_b);
                end else begin
                    grp_src  <= cur_src;
                    grp_left <= grp_now - GRP_LEN_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            out_data <= (cur_src == SRC_A) ? head_a : head_b;
        end
    end

endmodule

// File: rtl/dual_link_merger.sv
module dual_link_merger
    import dlm_pkg::*;
#(
    parameter int PIX_W      = 24,
    parameter int FIFO_DEPTH = 2048,
    parameter int LINE_MAX   = 4096,
    localparam int LW        = $clog2(LINE_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_mode,
    input  logic [LW-1:0]         cfg_line_len,
    input  logic [LW-1:0]         cfg_left_len,
    input  logic [GRP_CODE_W-1:0] cfg_grp_a,
    input  logic [GRP_CODE_W-1:0] cfg_grp_b,
    input  logic                  a_hss,
    input  logic                  a_valid,
    input  logic [PIX_W-1:0]      a_pixel,
    input  logic                  b_hss,
    input  logic                  b_valid,
    input  logic [PIX_W-1:0]      b_pixel,
    output logic                  out_valid,
    output logic [PIX_W-1:0]      out_pixel,
    output logic                  out_sol,
    output logic                  out_eol,
    output logic                  skew_err
);
    logic             empty_a;
    logic             empty_b;
    logic             pop_a;
    logic             pop_b;
    logic [PIX_W-1:0] head_a;
    logic [PIX_W-1:0] head_b;
    split_e           mode;

    assign mode = split_e'(cfg_mode);

    pix_fifo #(.W(PIX_W), .DEPTH(FIFO_DEPTH)) u_fifo_a (
        .clk   (clk),
        .rst   (rst),
        .push  (a_valid),
        .din   (a_pixel),
        .pop   (pop_a),
        .head  (head_a),
        .empty (empty_a)
    );

    pix_fifo #(.W(PIX_W), .DEPTH(FIFO_DEPTH)) u_fifo_b (
        .clk   (clk),
        .rst   (rst),
        .push  (b_valid),
        .din   (b_pixel),
        .pop   (pop_b),
        .head  (head_b),
        .empty (empty_b)
    );

    merge_sequencer #(.W(PIX_W), .LW(LW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .line_len  (cfg_line_len),
        .left_len  (cfg_left_len),
        .grp_a     (cfg_grp_a),
        .grp_b     (cfg_grp_b),
        .empty_a   (empty_a),
        .empty_b   (empty_b),
        .head_a    (head_a),
        .head_b    (head_b),
        .pop_a     (pop_a),
        .pop_b     (pop_b),
        .out_valid (out_valid),
        .out_data  (out_pixel),
        .out_sol   (out_sol),
        .out_eol   (out_eol)
    );

    skew_monitor u_skew (
        .clk   (clk),
        .rst   (rst),
        .hss_a (a_hss),
        .hss_b (b_hss),
        .err   (skew_err)
    );

endmodule

// File: rtl/merger_checks.sv
module merger_checks #(
    parameter int LW = 13
) (
    input logic          clk,
    input logic          rst,
    input logic          out_valid,
    input logic          out_sol,
    input logic          out_eol,
    input logic          skew_err,
    input logic [LW-1:0] line_len,
    input logic          pop_a,
    input logic          pop_b,
    input logic          empty_a,
    input logic          empty_b
);
    logic        in_line;
    logic [LW:0] beats;
    logic [LW:0] beats_now;

    assign beats_now = out_sol ? (LW+1)'(1) : beats + (LW+1)'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_line <= 1'b0;
            beats   <= '0;
        end else if (out_valid) begin
            in_line <= !out_eol;
            beats   <= beats_now;
        end
    end

    a_r5_sol_opens_line: assert property (@(posedge clk) disable iff (rst)
        out_valid && !in_line |-> out_sol);
    a_r5_no_sol_midline: assert property (@(posedge clk) disable iff (rst)
        out_valid && in_line |-> !out_sol);
    a_r5_line_len: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_eol |-> beats_now == {1'b0, line_len});
    a_r4_pop_a_nonempty: assert property (@(posedge clk) disable iff (rst)
        pop_a |-> !empty_a);
    a_r4_pop_b_nonempty: assert property (@(posedge clk) disable iff (rst)
        pop_b |-> !empty_b);
    a_r4_one_source: assert property (@(posedge clk) disable iff (rst)
        !(pop_a && pop_b));
    a_r9_pop_to_out: assert property (@(posedge clk) disable iff (rst)
        (pop_a || pop_b) |=> out_valid);
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        skew_err |=> skew_err);

endmodule

module fifo_checks #(
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input logic      clk,
    input logic      rst,
    input logic      push,
    input logic      pop,
    input logic [AW:0] fill
);
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push && !pop |-> fill < (AW+1)'(DEPTH));
endmodule

bind dual_link_merger merger_checks #(.LW(LW)) u_checks (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_sol   (out_sol),
    .out_eol   (out_eol),
    .skew_err  (skew_err),
    .line_len  (cfg_line_len),
    .pop_a     (pop_a),
    .pop_b     (pop_b),
    .empty_a   (empty_a),
    .empty_b   (empty_b)
);

bind pix_fifo fifo_checks #(.DEPTH(DEPTH), .AW(AW)) u_fifo_checks (
    .clk  (clk),
    .rst  (rst),
    .push (push),
    .pop  (pop),
    .fill (fill)
);

// File: tb/test_dual_link_merger.sv
module test_dual_link_merger;
    localparam int PW    = 16;
    localparam int DEPTH = 64;
    localparam int LMAX  = 255;
    localparam int LW    = $clog2(LMAX + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_mode = 1'b0;
    logic [LW-1:0] cfg_line_len = '0;
    logic [LW-1:0] cfg_left_len = '0;
    logic [5:0]    cfg_grp_a = '0;
    logic [5:0]    cfg_grp_b = '0;
    logic          a_hss = 1'b0, a_valid = 1'b0, b_hss = 1'b0, b_valid = 1'b0;
    logic [PW-1:0] a_pixel = '0, b_pixel = '0;
    logic          out_valid, out_sol, out_eol, skew_err;
    logic [PW-1:0] out_pixel;

    always #2 clk = ~clk;   // 250 MHz

    dual_link_merger #(.PIX_W(PW), .FIFO_DEPTH(DEPTH), .LINE_MAX(LMAX)) i_dual_link_merger (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_line_len(cfg_line_len),
        .cfg_left_len(cfg_left_len), .cfg_grp_a(cfg_grp_a), .cfg_grp_b(cfg_grp_b),
        .a_hss(a_hss), .a_valid(a_valid), .a_pixel(a_pixel),
        .b_hss(b_hss), .b_valid(b_valid), .b_pixel(b_pixel),
        .out_valid(out_valid), .out_pixel(out_pixel), .out_sol(out_sol),
        .out_eol(out_eol), .skew_err(skew_err)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [PW-1:0] mq_a[$];
    logic [PW-1:0] mq_b[$];
    int  m_pos = 0, m_gsel = 0, m_gleft = 0, m_lead = 0;
    bit  m_valid = 0, m_sol = 0, m_eol = 0, m_err = 0;
    logic [PW-1:0] m_data = '0;

    always @(posedge clk) begin
        if (rst) begin
            mq_a.delete(); mq_b.delete();
            m_pos = 0; m_gsel = 0; m_gleft = 0; m_lead = 0;
            m_valid = 0; m_sol = 0; m_eol = 0; m_err = 0;
        end else begin
            int src, gnow, len;
            bit have;
            len  = int'(cfg_line_len);
            if (cfg_mode == 1'b0) src = (m_pos >= int'(cfg_left_len)) ? 1 : 0;
            else                  src = (m_pos == 0) ? 0 : m_gsel;
            gnow = (m_pos == 0) ? int'(cfg_grp_a) + 1 : m_gleft;
            have = (src == 0) ? (mq_a.size() > 0) : (mq_b.size() > 0);
            m_valid = have && (len != 0);
            m_sol = 0; m_eol = 0;
            if (m_valid) begin
                m_data = (src == 0) ? mq_a.pop_front() : mq_b.pop_front();
                m_sol  = (m_pos == 0);
                m_eol  = (m_pos == len - 1);
                m_pos  = m_eol ? 0 : m_pos + 1;
                if (gnow == 1) begin
                    m_gsel  = 1 - src;
                    m_gleft = (m_gsel == 0) ? int'(cfg_grp_a) + 1 : int'(cfg_grp_b) + 1;
                end else begin
                    m_gsel  = src;
                    m_gleft = gnow - 1;
                end
            end
            if (a_valid) mq_a.push_back(a_pixel);
            if (b_valid) mq_b.push_back(b_pixel);
            if (a_hss && !b_hss) begin
                if (m_lead >= 1) m_err = 1;
                m_lead++;
            end else if (b_hss && !a_hss) begin
                if (m_lead <= -1) m_err = 1;
                m_lead--;
            end
        end
    end

    // ---------------- per-clock comparison and line collector ----------------
    int    exp_idx   = 0;
    int    cur_width = 0;
    int    line_base = 0;
    string cur_tag   = "R2";

    always @(negedge clk) begin
        if (!rst) begin
            check(out_valid == m_valid, "R9 output strobe timing", out_valid, m_valid);
            check(skew_err == m_err, "R7 skew flag", skew_err, m_err);
            if (out_valid && m_valid) begin
                check(out_pixel == m_data, "R4 model pixel", out_pixel, m_data);
            end
            if (out_valid) begin
                check(out_pixel == PW'(line_base + exp_idx), cur_tag, out_pixel, line_base + exp_idx);
                check(out_sol == (exp_idx == 0), "R5 start marker", out_sol, exp_idx == 0);
                check(out_eol == (exp_idx == cur_width - 1), "R5 end marker", out_eol, exp_idx == cur_width - 1);
                exp_idx++;
            end
        end
    end

    // ---------------- stimulus ----------------
    int line_id = 1;

    task automatic send_line(input int mode, input int width, input int left,
                             input int ga, input int gb, input int da, input int db,
                             input int gap_a, input int gap_b, input string tag);
        logic [PW-1:0] sa[$];
        logic [PW-1:0] sb[$];
        int src = 0;
        int rem = ga + 1;
        cfg_mode = mode[0]; cfg_line_len = LW'(width); cfg_left_len = LW'(left);
        cfg_grp_a = 6'(ga); cfg_grp_b = 6'(gb);
        line_base = line_id * 256;
        for (int i = 0; i < width; i++) begin
            logic [PW-1:0] px;
            px = PW'(line_base + i);
            if (mode == 0) begin
                if (i < left) sa.push_back(px); else sb.push_back(px);
            end else begin
                if (src == 0) sa.push_back(px); else sb.push_back(px);
                rem--;
                if (rem == 0) begin
                    src = 1 - src;
                    rem = (src == 0) ? ga + 1 : gb + 1;
                end
            end
        end
        exp_idx = 0; cur_width = width; cur_tag = tag;
        @(negedge clk);
        fork
            begin
                repeat (da) @(negedge clk);
                a_hss = 1'b1; @(negedge clk); a_hss = 1'b0;
                for (int k = 0; k < sa.size(); k++) begin
                    a_valid = 1'b1; a_pixel = sa[k]; @(negedge clk);
                    if (gap_a != 0 && (k % gap_a) == gap_a - 1) begin
                        a_valid = 1'b0; @(negedge clk);
                    end
                end
                a_valid = 1'b0;
            end
            begin
                repeat (db) @(negedge clk);
                b_hss = 1'b1; @(negedge clk); b_hss = 1'b0;
                for (int k = 0; k < sb.size(); k++) begin
                    b_valid = 1'b1; b_pixel = sb[k]; @(negedge clk);
                    if (gap_b != 0 && (k % gap_b) == gap_b - 1) begin
                        b_valid = 1'b0; @(negedge clk);
                    end
                end
                b_valid = 1'b0;
            end
        join
        while (exp_idx < width) @(negedge clk);
        repeat (3) @(negedge clk);
        check(exp_idx == width, "R5 beats per line", exp_idx, width);
        line_id++;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired, actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(out_sol == 1'b0 && out_eol == 1'b0, "R1 markers after reset", {out_sol, out_eol}, 0);
        check(skew_err == 1'b0, "R1 skew_err after reset", skew_err, 0);

        // R2 halves split with packet gaps on both links
        send_line(0, 20, 12, 0, 0, 0, 0, 5, 3, "R2 halves order");
        send_line(0, 20, 12, 0, 0, 0, 0, 0, 0, "R2 halves order");
        // R4 link B late by a fixed skew
        send_line(0, 16, 4, 0, 0, 0, 5, 0, 0, "R4 late link B");
        // R3 equal groups of 4, link B skewed and gappy
        send_line(1, 24, 0, 3, 3, 0, 7, 0, 2, "R3 groups 4/4");
        // R3 unequal groups 1 and 3, link A in several packets
        send_line(1, 16, 0, 0, 2, 0, 0, 1, 0, "R3 groups 1/3");
        // R6 line ends inside a link-A group, twice in a row
        send_line(1, 10, 0, 3, 3, 0, 0, 0, 0, "R6 mid-group end");
        send_line(1, 10, 0, 3, 3, 0, 2, 0, 0, "R6 restart on link A");
        // R8 groups of 64: link B buffer fills completely
        send_line(1, 128, 0, 63, 63, 0, 0, 0, 0, "R8 full-depth group");
        // R4 link B starts slightly earlier (simultaneous window)
        send_line(0, 8, 4, 0, 0, 3, 0, 0, 0, "R4 early link B");
        check(skew_err == 1'b0, "R7 no error for consistent starts", skew_err, 0);

        // R7 two link-A starts with no link-B start in between
        @(negedge clk); a_hss = 1'b1; @(negedge clk); a_hss = 1'b0;
        repeat (3) @(negedge clk);
        check(skew_err == 1'b0, "R7 one line of lead allowed", skew_err, 0);
        a_hss = 1'b1; @(negedge clk); a_hss = 1'b0;
        @(negedge clk);
        check(skew_err == 1'b1, "R7 error on second lead", skew_err, 1);
        b_hss = 1'b1; @(negedge clk); b_hss = 1'b0;
        repeat (5) @(negedge clk);
        check(skew_err == 1'b1, "R7 error stays set", skew_err, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule